// File: doc/BRIEF.md
# Quad Programmable Edge Deskew

This block aligns four sampled test-pattern signals in time. Each channel holds its input in a shift history and reproduces it a programmable number of clock cycles later. A second, signed setting moves only the falling edge of each pulse, so a channel can widen or narrow the pulses it passes on. Rise and fall timing are set per channel.

A common mode input selects the behaviour. In plain delay mode the output is the delayed input and both edges move together. In edge-control mode a rising event sets and a falling event clears an output flip-flop. The two events are scheduled separately. That flip-flop holds an unknown value until the first event reaches it, so each channel raises a valid flag once its output can be trusted. A fanout input sends the second channel's input into all four delay paths. Each path keeps its own settings.

Top module: `quad_edge_deskew`

## Requirements
- R1: In plain delay mode (`edge_mode` = 0), `dout[c]` after clock edge n equals the channel's source sampled at edge n-1-D, where D is the channel's delay setting. The width setting has no effect in this mode.
- R2: In edge-control mode (`edge_mode` = 1), a source rise sampled at edge n drives `dout[c]` high after edge n+D+1. The rise time depends on D only.
- R3: In edge-control mode, a source fall sampled at edge m drives `dout[c]` low after edge m+P+1, with P = max(D+W, 0). W is the width setting, read as a two's-complement number from -8 to +7.
- R4: If a pulse's clear time is at or before its own set time, that pulse produces no high output. When a set and a clear fall in the same cycle, the output goes low.
- R5: `dout_vld[c]` is 0 after reset and goes to 1 on the first edge taken in plain delay mode. It stays 1 for as long as plain delay mode lasts. On entry into edge-control mode it is cleared. It is set again when the channel's first set or clear event fires.
- R6: While `fanout` = 1, every channel takes `din[1]` as its source. The other three inputs are ignored. Each channel still applies its own D and W.
- R7: A channel loads new D and W values only at an edge where its source has held one value for that sample and the previous 40 samples. The 40 is the maximum D plus the maximum W, plus 2. At any other edge the old settings stay in force.
- R8: While `rst_n` is low, `dout` and `dout_vld` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 4 | Per-channel input samples |
| dly_cfg | input | 20 | Delay setting D, 5 unsigned bits per channel; channel c at bits [5c+4:5c] |
| wid_cfg | input | 16 | Falling-edge offset W, 4 signed bits per channel; channel c at bits [4c+3:4c] |
| edge_mode | input | 1 | 0 selects plain delay mode, 1 selects edge-control mode |
| fanout | input | 1 | 1 routes din[1] into all four delay paths |
| dout | output | 4 | Delayed outputs |
| dout_vld | output | 4 | Per-channel output-valid flags |

## Verification
The properties are checked on every cycle. They cover:
- the output going low when a clear event fires, even with a set in the same cycle;
- the output rising on an unopposed set;
- the valid flag being held, being forced high in plain mode, and being cleared on entry into edge-control mode;
- the delay and width settings being frozen while any edge is still in the history window.

Other behaviours only the bench's scenarios can show, comparing against its behavioural event-schedule model:
- the exact cycle at which each edge emerges for a given D and W;
- the clamping of the falling position at zero;
- the swallowing of pulses shrunk to nothing;
- fanout ignoring the other inputs;
- the moment a deferred setting finally takes hold.

// File: rtl/deskew_pkg.sv
package deskew_pkg;

   // Events produced by the edge scheduler for one channel in one cycle
   typedef struct packed {
      logic set;
      logic clr;
   } edge_ev_t;

   // Falling-edge position in the history, never below zero
   function automatic int fall_pos(input int dly, input int wid);
      int p;
      p = dly + wid;
      return (p < 0) ? 0 : p;
   endfunction

endpackage

// File: rtl/deskew_history.sv
module deskew_history #(
   parameter int DEPTH = 64,
   parameter int SPAN  = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src,
   output logic [DEPTH-1:0] hist,
   output logic             quiet
);

   // hist[k] holds the source sampled k+1 edges ago, as seen between edges
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist <= '0;
      else        hist <= {hist[DEPTH-2:0], src};
   end

   // No transition anywhere in the window any scheduled edge could read
   assign quiet = (hist[SPAN-1:0] == {SPAN{src}});

endmodule

// File: rtl/deskew_edge_sched.sv
module deskew_edge_sched
   import deskew_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int DLY_W = 5,
   parameter int WID_W = 4
) (
   input  logic [DEPTH-1:0]        hist,
   input  logic [DLY_W-1:0]        dly,
   input  logic signed [WID_W-1:0] wid,
   output logic                    tap,
   output edge_ev_t                ev
);

   localparam int IW = $clog2(DEPTH);

   int               dv;
   int               pv;
   logic [IW-1:0]    d_idx;
   logic [IW-1:0]    d_nxt;
   logic [IW-1:0]    p_idx;
   logic [IW-1:0]    p_nxt;
   logic [DEPTH-1:0] win;
   logic             short_pulse;

   always_comb begin
      dv    = int'(dly);
      pv    = fall_pos(dv, int'(wid));
      d_idx = IW'(dv);
      d_nxt = IW'(dv + 1);
      p_idx = IW'(pv);
      p_nxt = IW'(pv + 1);
      // Samples newer than the rise but not yet past the fall position
      for (int j = 0; j < DEPTH; j++) begin
         win[j] = (j >= pv) && (j < dv);
      end
      // The pulse ended early enough that its clear is due at or before its set
      short_pulse = |(~hist & win);
      tap    = hist[d_idx];
      ev.set = hist[d_idx] & ~hist[d_nxt] & ~short_pulse;
      ev.clr = ~hist[p_idx] & hist[p_nxt];
   end

endmodule

// File: rtl/deskew_channel.sv
module deskew_channel
   import deskew_pkg::*;
#(
   parameter int HIST_DEPTH = 64,
   parameter int DLY_W      = 5,
   parameter int WID_W      = 4,
   parameter int SPAN       = 40
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    src,
   input  logic                    edge_mode,
   input  logic [DLY_W-1:0]        dly_in,
   input  logic signed [WID_W-1:0] wid_in,
   output logic                    dout,
   output logic                    dout_vld
);

   logic [HIST_DEPTH-1:0]   hist;
   logic                    quiet;
   logic [DLY_W-1:0]        d_q;
   logic signed [WID_W-1:0] w_q;
   logic                    tap;
   edge_ev_t                ev;
   logic                    mode_d;
   logic                    out_q;
   logic                    vld_q;

   deskew_history #(.DEPTH(HIST_DEPTH), .SPAN(SPAN)) u_hist (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (src),
      .hist  (hist),
      .quiet (quiet)
   );

   deskew_edge_sched #(.DEPTH(HIST_DEPTH), .DLY_W(DLY_W), .WID_W(WID_W)) u_sched (
      .hist (hist),
      .dly  (d_q),
      .wid  (w_q),
      .tap  (tap),
      .ev   (ev)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d_q    <= '0;
         w_q    <= '0;
         mode_d <= 1'b0;
         out_q  <= 1'b0;
         vld_q  <= 1'b0;
      end else begin
         mode_d <= edge_mode;
         if (quiet) begin
            d_q <= dly_in;
            w_q <= wid_in;
         end
         if (!edge_mode) begin
            out_q <= tap;
            vld_q <= 1'b1;
         end else begin
            if (ev.clr)      out_q <= 1'b0;
            else if (ev.set) out_q <= 1'b1;
            vld_q <= (mode_d & vld_q) | ev.set | ev.clr;
         end
      end
   end

   assign dout     = out_q;
   assign dout_vld = vld_q;

   // R4: a clear event wins over any set in the same cycle
   p_clr_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && ev.clr) |=> !out_q);

   // R2: an unopposed set drives the output high
   p_set_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && ev.set && !ev.clr) |=> out_q);

   // R5: plain mode always yields a valid output
   p_plain_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !edge_mode |=> vld_q);

   // R5: entering edge mode without an event clears the flag
   p_entry_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && !mode_d && !ev.set && !ev.clr) |=> !vld_q);

   // R5: once valid in edge mode, the flag stays set
   p_vld_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && mode_d && vld_q) |=> vld_q);

   // R7: settings never change while an edge is still in flight
   p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !quiet |=> ($stable(d_q) && $stable(w_q)));

endmodule

// File: rtl/quad_edge_deskew.sv
module quad_edge_deskew #(
   parameter int NCH        = 4,
   parameter int DLY_W      = 5,
   parameter int WID_W      = 4,
   parameter int HIST_DEPTH = 64,
   parameter int FAN_SRC    = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NCH-1:0]         din,
   input  logic [NCH*DLY_W-1:0]   dly_cfg,
   input  logic [NCH*WID_W-1:0]   wid_cfg,
   input  logic                   edge_mode,
   input  logic                   fanout,
   output logic [NCH-1:0]         dout,
   output logic [NCH-1:0]         dout_vld
);

   localparam int DLY_MAX = (1 << DLY_W) - 1;
   localparam int WID_MAX = (1 << (WID_W - 1)) - 1;
   localparam int SPAN    = DLY_MAX + WID_MAX + 2;

   if (HIST_DEPTH < SPAN) begin : g_bad_depth
      $error("HIST_DEPTH must cover the largest delay plus width");
   end
   if (FAN_SRC >= NCH) begin : g_bad_src
      $error("FAN_SRC must name an existing channel");
   end
   if (WID_W < 2) begin : g_bad_wid
      $error("WID_W must be at least 2 bits");
   end

   logic [NCH-1:0] src;

   assign src = fanout ? {NCH{din[FAN_SRC]}} : din;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      deskew_channel #(
         .HIST_DEPTH (HIST_DEPTH),
         .DLY_W      (DLY_W),
         .WID_W      (WID_W),
         .SPAN       (SPAN)
      ) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .src       (src[c]),
         .edge_mode (edge_mode),
         .dly_in    (dly_cfg[c*DLY_W +: DLY_W]),
         .wid_in    (wid_cfg[c*WID_W +: WID_W]),
         .dout      (dout[c]),
         .dout_vld  (dout_vld[c])
      );
   end

endmodule

// File: tb/quad_edge_deskew_bench.sv
module quad_edge_deskew_bench;

   localparam int NCH  = 4;
   localparam int DW   = 5;
   localparam int WW   = 4;
   localparam int SPAN = 40;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NCH-1:0]    din = '0;
   logic [NCH*DW-1:0] dly_cfg = '0;
   logic [NCH*WW-1:0] wid_cfg = '0;
   logic              edge_mode = 1'b0;
   logic              fanout = 1'b0;
   logic [NCH-1:0]    dout;
   logic [NCH-1:0]    dout_vld;

   int    checks = 0;
   int    errors = 0;
   bit    done = 0;
   string cur_req = "R8";

   quad_edge_deskew u_quad_edge_deskew (
      .clk       (clk),
      .rst_n     (rst_n),
      .din       (din),
      .dly_cfg   (dly_cfg),
      .wid_cfg   (wid_cfg),
      .edge_mode (edge_mode),
      .fanout    (fanout),
      .dout      (dout),
      .dout_vld  (dout_vld)
   );

   always #2 clk = ~clk;

   // Behavioural model: sample log plus a schedule of set/clear times
   int cyc;
   bit m_out [NCH];
   bit m_vld [NCH];
   int md [NCH];
   int mw [NCH];
   bit last [NCH];
   int run [NCH];
   int lastset [NCH];
   bit mprev;
   bit smp [int];
   bit sset [int];
   bit srst [int];

   function automatic int key(input int c, input int t);
      return c * 1000000 + t;
   endfunction

   function automatic bit sample_at(input int c, input int t);
      if (t < 1) return 1'b0;
      if (smp.exists(key(c, t))) return smp[key(c, t)];
      return 1'b0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         cyc = 0;
         mprev = 0;
         smp.delete();
         sset.delete();
         srst.delete();
         for (int c = 0; c < NCH; c++) begin
            m_out[c] = 0; m_vld[c] = 0; md[c] = 0; mw[c] = 0;
            last[c] = 0; run[c] = SPAN; lastset[c] = -1000;
         end
      end else begin
         cyc++;
         for (int c = 0; c < NCH; c++) begin
            bit s;
            bit r;
            bit src;
            src = fanout ? din[1] : din[c];
            if (!edge_mode) begin
               m_out[c] = sample_at(c, cyc - 1 - md[c]);
               m_vld[c] = 1;
            end else begin
               s = sset.exists(key(c, cyc));
               r = srst.exists(key(c, cyc));
               if (r)      m_out[c] = 0;
               else if (s) m_out[c] = 1;
               m_vld[c] = (mprev && m_vld[c]) || s || r;
            end
            if (src == last[c] && run[c] >= SPAN) begin
               md[c] = int'(dly_cfg[c*DW +: DW]);
               mw[c] = int'($signed(wid_cfg[c*WW +: WW]));
            end
            smp[key(c, cyc)] = src;
            if (src != last[c]) begin
               if (src) begin
                  lastset[c] = cyc + md[c] + 1;
                  sset[key(c, lastset[c])] = 1;
               end else begin
                  int pf;
                  int rk;
                  pf = md[c] + mw[c];
                  if (pf < 0) pf = 0;
                  rk = cyc + pf + 1;
                  if (rk <= lastset[c]) sset.delete(key(c, lastset[c]));
                  srst[key(c, rk)] = 1;
               end
               run[c] = 1;
               last[c] = src;
            end else begin
               run[c]++;
            end
         end
         mprev = edge_mode;
      end
   end

   // Compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         for (int c = 0; c < NCH; c++) begin
            checks++;
            if (dout_vld[c] !== m_vld[c]) begin
               errors++;
               $display("FAIL %s ch%0d dout_vld actual=%0b expected=%0b cycle %0d",
                        cur_req, c, dout_vld[c], m_vld[c], cyc);
            end
            if (m_vld[c]) begin
               checks++;
               if (dout[c] !== m_out[c]) begin
                  errors++;
                  $display("FAIL %s ch%0d dout actual=%0b expected=%0b cycle %0d",
                           cur_req, c, dout[c], m_out[c], cyc);
               end
            end
         end
      end
   end

   task automatic wait_cycles(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic drive_random(input int cycles, input int p);
      repeat (cycles) begin
         @(negedge clk);
         for (int c = 0; c < NCH; c++) begin
            if ($urandom_range(p - 1) == 0) din[c] = ~din[c];
         end
      end
   endtask

   task automatic set_cfg(input int d0, input int d1, input int d2, input int d3,
                          input int w0, input int w1, input int w2, input int w3);
      dly_cfg = {DW'(d3), DW'(d2), DW'(d1), DW'(d0)};
      wid_cfg = {WW'(w3), WW'(w2), WW'(w1), WW'(w0)};
   endtask

   task automatic settle();
      wait_cycles(SPAN + 6);
   endtask

   initial begin
      // R8: reset state
      wait_cycles(3);
      checks++;
      if (dout !== '0 || dout_vld !== '0) begin
         errors++;
         $display("FAIL R8 reset dout=%b vld=%b actual, expected=0000/0000", dout, dout_vld);
      end
      rst_n = 1'b1;

      // R1: plain delay, width values must be ignored
      cur_req = "R1";
      set_cfg(3, 7, 0, 31, 5, -3, 7, -8);
      settle();
      drive_random(400, 3);
      din = '0;
      settle();

      // R2: edge-control mode, rise timing with modest widths
      cur_req = "R2";
      edge_mode = 1'b1;
      set_cfg(4, 10, 2, 20, 0, 0, 0, 0);
      settle();
      drive_random(300, 6);
      din = '0;
      settle();

      // R3: signed falling offsets, stretch and shrink
      cur_req = "R3";
      set_cfg(4, 10, 2, 20, 3, -2, 7, -4);
      settle();
      drive_random(400, 6);
      din = '0;
      settle();

      // R4: heavy shrink, clamped fall position, swallowed pulses
      cur_req = "R4";
      set_cfg(6, 2, 31, 12, -8, -5, -8, -1);
      settle();
      drive_random(400, 4);
      din = '0;
      settle();

      // R5: mode switching amid traffic
      cur_req = "R5";
      set_cfg(5, 1, 9, 3, 2, -1, 4, 0);
      settle();
      for (int i = 0; i < 8; i++) begin
         edge_mode = ~edge_mode;
         drive_random(60, 4);
      end
      din = '0;
      settle();

      // R6: fanout from channel index 1, per-channel settings kept
      cur_req = "R6";
      fanout = 1'b1;
      edge_mode = 1'b1;
      set_cfg(0, 8, 15, 27, 5, -3, 0, 7);
      settle();
      drive_random(400, 3);
      edge_mode = 1'b0;
      drive_random(200, 3);
      fanout = 1'b0;
      din = '0;
      settle();

      // R7: settings changed while edges are in flight
      cur_req = "R7";
      edge_mode = 1'b1;
      for (int i = 0; i < 30; i++) begin
         set_cfg($urandom_range(31), $urandom_range(31), $urandom_range(31), $urandom_range(31),
                 $urandom_range(15) - 8, $urandom_range(15) - 8,
                 $urandom_range(15) - 8, $urandom_range(15) - 8);
         drive_random(10, 2);
      end
      din = '0;
      settle();
      drive_random(200, 5);
      din = '0;
      settle();

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 100000);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL %s watchdog actual=timeout expected=completion", cur_req);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule